// File: doc/BRIEF.md
# Bus Bridge Configuration Register

This block is the single configuration word held inside a bridge that connects a fast system bus to a slower peripheral bus. The bridge's register port issues a one-cycle request carrying a word address, a write flag, write data and a privilege flag. One clock edge later the block answers with read data and an error flag. The block holds three settings and drives them continuously to the rest of the bridge:

- a stop control for the peripheral-bus clock;
- a two-bit mode that selects how many interrupt sources are time-multiplexed onto the peripheral interrupt lines;
- a half-speed select that sets the peripheral-bus clock ratio.

The half-speed select can only move from 1 to 0. Once it has been cleared it stays at 0 until the next reset.

The block decodes a small power-of-two window of word addresses that contains its own register. Every other word in that window is fully reserved. The register itself is only partly reserved, because bits beyond the three fields are simply unimplemented. The request port is a plain strobe with no back-pressure: every request is accepted in the cycle it is presented, and nothing streams through the block. Bits are numbered here as hardware indices, with bit 31 the most significant.

Top module: `bbc_cfg_reg`

## Requirements
- R1: Reset state. While reset is asserted and after it is released, `clk_stop` is 0, `irq_mux_mode` is 00, `half_speed` is 1, `rsp_err` is 0 and `rsp_rdata` is zero.
- R2: Supervisor write. A write with `req_super`=1 to word address `BASE_ADDR` updates the outputs at the next clock edge: `clk_stop` takes write bit 31, and `irq_mux_mode` takes write bits 30:29, with bit 30 as its upper bit.
- R3: Half-speed lock. A supervisor write to `BASE_ADDR` sets `half_speed` to its current value ANDed with write bit 28. A 1 written while the field is 1 keeps it at 1. Once a 0 has been written, later writes of 1 leave it at 0 until reset.
- R4: Supervisor read. A read with `req_super`=1 of `BASE_ADDR` returns, on `rsp_rdata` after the next clock edge, {`clk_stop`, `irq_mux_mode`, `half_speed`} in bits 31:28 and zero in bits 27:0, with `rsp_err`=0. Bits 27:0 of a write are discarded and never read back. A read changes no setting.
- R5: Privilege check. Any request with `req_super`=0 to a word inside the decoded window yields `rsp_err`=1 and zero `rsp_rdata` after the next edge, and leaves all three settings unchanged.
- R6: Reserved words. A supervisor request to a window word other than `BASE_ADDR` yields `rsp_err`=1 and zero `rsp_rdata`, and changes no setting. The window is the `WIN_WORDS` aligned words sharing the address bits above log2(`WIN_WORDS`) with `BASE_ADDR`.
- R7: Addresses outside the window get no response: `rsp_err`=0, zero `rsp_rdata` and no setting change.
- R8: One-cycle response. After a cycle with `req_en`=0, `rsp_err` is 0 and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_en | input | 1 | Register request strobe, one cycle per access |
| req_we | input | 1 | 1 = write, 0 = read |
| req_waddr | input | ADDR_W (24) | Word address of the access |
| req_wdata | input | DATA_W (32) | Write data |
| req_super | input | 1 | 1 = supervisor access, 0 = user access |
| rsp_rdata | output | DATA_W (32) | Read data, valid the cycle after a request |
| rsp_err | output | 1 | Data error pulse, the cycle after a rejected request |
| clk_stop | output | 1 | 1 = stop the peripheral-bus clock |
| irq_mux_mode | output | 2 | 00 none, 01 2:1, 10 3:1, 11 4:1 interrupt multiplexing |
| half_speed | output | 1 | 1 = peripheral bus at half frequency, 0 = same frequency |

## Verification
Two pairs of conditions can fall on the same request, and both are provoked and judged.

The first pair is the half-speed lock and an ordinary field update. A single supervisor write both clears or re-sets the stop and mode fields and tries to raise a half-speed field that is already locked. The bench walks all sixteen values of the top nibble through consecutive writes and read-backs. Each result is compared with a model that takes the stop and mode fields from the write and ANDs the half-speed bit.

The second pair is the privilege rejection and the reserved-word rejection. A user request aimed at a reserved word meets both conditions at once. The sweep crosses privilege, direction, every window word, and addresses on each side of the window. It expects exactly one error pulse and untouched settings.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

  // Field placement counted from the most significant bit of the word.
  localparam int STOP_IDX  = 0;
  localparam int MODE_IDX  = 1;
  localparam int MODE_W    = 2;
  localparam int HS_IDX    = 3;
  localparam int USED_BITS = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_RSVD = 2'd2
  } sel_e;

  typedef struct packed {
    logic              stop;
    logic [MODE_W-1:0] mode;
    logic              hs;
  } cfg_t;

endpackage

// File: rtl/bbc_decode.sv
module bbc_decode
  import bbc_pkg::*;
#(
  parameter int              ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h30_7F80,
  parameter int              WIN_WORDS = 8
) (
  input  logic [ADDR_W-1:0] waddr,
  output sel_e              sel
);

  localparam int WIN_BITS = $clog2(WIN_WORDS);

  generate
    if (WIN_WORDS <= 1) begin : g_single
      always_comb sel = (waddr == BASE_ADDR) ? SEL_CFG : SEL_NONE;
    end else begin : g_window
      localparam logic [WIN_BITS-1:0] CFG_OFF = BASE_ADDR[WIN_BITS-1:0];
      logic hit;
      assign hit = (waddr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
      always_comb begin
        if (!hit)                               sel = SEL_NONE;
        else if (waddr[WIN_BITS-1:0] == CFG_OFF) sel = SEL_CFG;
        else                                    sel = SEL_RSVD;
      end
    end
  endgenerate

endmodule

// File: rtl/bbc_access.sv
module bbc_access
  import bbc_pkg::*;
(
  input  logic req_en,
  input  logic req_we,
  input  logic req_super,
  input  sel_e sel,
  output logic wr_cfg,
  output logic rd_cfg,
  output logic err_req
);

  logic granted;

  always_comb begin
    granted = req_en && req_super && (sel == SEL_CFG);
    wr_cfg  = granted && req_we;
    rd_cfg  = granted && !req_we;
    err_req = req_en && (sel != SEL_NONE) && !granted;
  end

endmodule

// File: rtl/bbc_fields.sv
module bbc_fields
  import bbc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] image
);

  localparam int STOP_B  = DATA_W - 1 - STOP_IDX;
  localparam int MODE_HI = DATA_W - 1 - MODE_IDX;
  localparam int HS_B    = DATA_W - 1 - HS_IDX;
  localparam logic [DATA_W-1:0] IMPL_MASK =
    {{USED_BITS{1'b1}}, {(DATA_W - USED_BITS){1'b0}}};
  localparam logic [DATA_W-1:0] HS_ONLY = DATA_W'(1) << HS_B;

  logic [DATA_W-1:0] img_q;
  logic [DATA_W-1:0] keep_mask;

  // Once the half-speed bit is low, it is masked out of every later write.
  always_comb keep_mask = img_q[HS_B] ? '1 : ~HS_ONLY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     img_q <= HS_ONLY;
    else if (wr_en) img_q <= wdata & IMPL_MASK & keep_mask;
  end

  always_comb begin
    cfg.stop = img_q[STOP_B];
    cfg.mode = img_q[MODE_HI -: MODE_W];
    cfg.hs   = img_q[HS_B];
  end

  assign image = img_q;

endmodule

// File: rtl/bbc_resp.sv
module bbc_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cfg,
  input  logic              err_req,
  input  logic [DATA_W-1:0] image,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_rdata <= rd_cfg ? image : '0;
      rsp_err   <= err_req;
    end
  end

endmodule

// File: rtl/bbc_cfg_reg.sv
module bbc_cfg_reg
  import bbc_pkg::*;
#(
  parameter int              ADDR_W    = 24,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h30_7F80,
  parameter int              WIN_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_en,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_waddr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_super,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              clk_stop,
  output logic [MODE_W-1:0] irq_mux_mode,
  output logic              half_speed
);

  sel_e              sel;
  logic              wr_cfg;
  logic              rd_cfg;
  logic              err_req;
  cfg_t              cfg;
  logic [DATA_W-1:0] image;

  bbc_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .WIN_WORDS(WIN_WORDS)
  ) u_decode (
    .waddr(req_waddr),
    .sel  (sel)
  );

  bbc_access u_access (
    .req_en   (req_en),
    .req_we   (req_we),
    .req_super(req_super),
    .sel      (sel),
    .wr_cfg   (wr_cfg),
    .rd_cfg   (rd_cfg),
    .err_req  (err_req)
  );

  bbc_fields #(.DATA_W(DATA_W)) u_fields (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_cfg),
    .wdata(req_wdata),
    .cfg  (cfg),
    .image(image)
  );

  bbc_resp #(.DATA_W(DATA_W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_cfg   (rd_cfg),
    .err_req  (err_req),
    .image    (image),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err)
  );

  assign clk_stop     = cfg.stop;
  assign irq_mux_mode = cfg.mode;
  assign half_speed   = cfg.hs;

endmodule

// File: rtl/bbc_cfg_chk.sv
module bbc_cfg_chk #(
  parameter int              ADDR_W    = 24,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h30_7F80,
  parameter int              WIN_WORDS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_en,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_waddr,
  input logic [2:0]        wr_top,
  input logic              req_super,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              clk_stop,
  input logic [1:0]        irq_mux_mode,
  input logic              half_speed
);

  localparam int WB = $clog2(WIN_WORDS);

  logic outside;
  assign outside = (req_waddr[ADDR_W-1:WB] != BASE_ADDR[ADDR_W-1:WB]);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_en |=> (!rsp_err && rsp_rdata == '0)); // R8

  AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rdata[DATA_W-5:0] == '0); // R4

  AST_HS_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(half_speed)); // R3

  AST_USER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && !req_super) |=> $stable({clk_stop, irq_mux_mode, half_speed})); // R5

  AST_USER_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && !req_super) |=> (rsp_rdata == '0)); // R5

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0)); // R6

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && req_we && req_super && req_waddr == BASE_ADDR)
    |=> ({clk_stop, irq_mux_mode} == $past(wr_top))); // R2

  AST_OUTSIDE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && outside) |=> !rsp_err); // R7

endmodule

bind bbc_cfg_reg bbc_cfg_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .BASE_ADDR(BASE_ADDR),
  .WIN_WORDS(WIN_WORDS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_en      (req_en),
  .req_we      (req_we),
  .req_waddr   (req_waddr),
  .wr_top      (req_wdata[DATA_W-1 -: 3]),
  .req_super   (req_super),
  .rsp_rdata   (rsp_rdata),
  .rsp_err     (rsp_err),
  .clk_stop    (clk_stop),
  .irq_mux_mode(irq_mux_mode),
  .half_speed  (half_speed)
);

// File: tb/bbc_cfg_reg_tb.sv
module bbc_cfg_reg_tb;

  localparam int          CLK_P = 10;
  localparam int          WD_CYC = 100000;
  localparam logic [23:0] BASE = 24'h30_7F80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_en = 1'b0;
  logic        req_we = 1'b0;
  logic [23:0] req_waddr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_super = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        clk_stop;
  logic [1:0]  irq_mux_mode;
  logic        half_speed;

  int errors = 0;
  int checks = 0;

  logic       m_stop;
  logic [1:0] m_mode;
  logic       m_hs;

  always #(CLK_P / 2) clk = ~clk;

  bbc_cfg_reg u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_en      (req_en),
    .req_we      (req_we),
    .req_waddr   (req_waddr),
    .req_wdata   (req_wdata),
    .req_super   (req_super),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err),
    .clk_stop    (clk_stop),
    .irq_mux_mode(irq_mux_mode),
    .half_speed  (half_speed)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_fields(input string req);
    check(req, "clk_stop", 32'(clk_stop), 32'(m_stop));
    check(req, "irq_mux_mode", 32'(irq_mux_mode), 32'(m_mode));
    check("R3", "half_speed", 32'(half_speed), 32'(m_hs));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_stop = 1'b0; m_mode = 2'b00; m_hs = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", "rsp_err", 32'(rsp_err), 32'd0);
    check("R1", "rsp_rdata", rsp_rdata, 32'd0);
    check_fields("R1");
  endtask

  task automatic access(input logic we, input logic [23:0] a,
                        input logic [31:0] d, input logic sup);
    logic        inwin, iscfg, exp_err;
    logic [31:0] exp_rd;
    string       tag;
    inwin   = (a[23:3] == BASE[23:3]);
    iscfg   = inwin && (a[2:0] == BASE[2:0]);
    exp_err = inwin && (!sup || !iscfg);
    exp_rd  = (!we && sup && iscfg) ? {m_stop, m_mode, m_hs, 28'h0} : 32'h0;
    if (!inwin)      tag = "R7";
    else if (!sup)   tag = "R5";
    else if (!iscfg) tag = "R6";
    else if (we)     tag = "R2";
    else             tag = "R4";
    @(negedge clk);
    req_en = 1'b1; req_we = we; req_waddr = a; req_wdata = d; req_super = sup;
    if (we && sup && iscfg) begin
      m_stop = d[31];
      m_mode = d[30:29];
      m_hs   = m_hs & d[28];
    end
    @(negedge clk);
    req_en = 1'b0; req_we = 1'b0;
    check(tag, "rsp_err", 32'(rsp_err), 32'(exp_err));
    check(tag, "rsp_rdata", rsp_rdata, exp_rd);
    check_fields(tag);
    // R8: the response lasts a single cycle
    @(negedge clk);
    check("R8", "rsp_err idle", 32'(rsp_err), 32'd0);
    check("R8", "rsp_rdata idle", rsp_rdata, 32'd0);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();

    // R3: half-speed lock sequence, then release by reset
    access(1'b1, BASE, 32'h1000_0000, 1'b1);
    access(1'b0, BASE, 32'h0, 1'b1);
    access(1'b1, BASE, 32'h0000_0000, 1'b1);
    access(1'b1, BASE, 32'hF000_0000, 1'b1);
    access(1'b0, BASE, 32'h0, 1'b1);
    do_reset();
    check("R3", "half_speed after reset", 32'(half_speed), 32'd1);

    // R2 R4: every top-nibble value written and read back, reserved bits set
    for (int n = 15; n >= 0; n--) begin
      access(1'b1, BASE, {4'(n), 28'hFFF_FFFF}, 1'b1);
      access(1'b0, BASE, 32'h0, 1'b1);
    end

    // R5 R6 R7: sweep of privilege, direction, window words and neighbours
    do_reset();
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 2; w++) begin
        for (int ai = 0; ai < 10; ai++) begin
          for (int n = 0; n < 16; n++) begin
            logic [23:0] a;
            if (ai < 8)       a = BASE + 24'(ai);
            else if (ai == 8) a = BASE + 24'd8;
            else              a = BASE - 24'd1;
            access(1'(w), a, {4'(n ^ 9), 28'h5A5_A5A5}, 1'(s));
          end
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule